// File: doc/BRIEF.md
# Interrupt and Status Control Register File

This block holds the privileged control state a hart consults for interrupts and traps: the machine status word, the interrupt pending, enable and delegation masks, two trap-vector bases and two counter-enable masks. Software reaches it through a single-cycle register port. Reads are combinational on the address. Writes commit on the next rising clock edge. Every writable field passes through a legality filter, so illegal values are never stored.

The supervisor status, pending and enable registers have no storage of their own. They are masked windows onto the machine registers. The supervisor pending and enable windows are cut by the current delegation mask. A small memory-mapped store port lets another agent raise or drop the machine software interrupt. A write to the status word that alters an address-translation control produces a one-cycle flush pulse for the TLB. Trap entry and interrupt arbitration live elsewhere.

Top module: `csr_file`

## Requirements
- R1: The delegation register (address 0x303) keeps only bits 1, 5, 9 and 12, which are supervisor software, supervisor timer, supervisor external and coprocessor. All other bits read as zero.
- R2: The enable register (0x304) keeps the delegable bits plus bit 3 (machine software) and bit 7 (machine timer). All other bits read as zero.
- R3: Writes to the pending register (0x344) change only bits 1 and 5. All other pending bits are unchanged.
- R4: The supervisor pending view (0x144) reads as pending AND delegation, and the supervisor enable view (0x104) reads as enable AND delegation. A write through either view changes only the delegated bits; R3 and R2 then still apply.
- R5: Writes to the machine trap vector (0x305) or the supervisor trap vector (0x105) store the value with bits 1:0 forced to zero.
- R6: The previous-privilege field of the machine status word (0x300, bits 12:11) takes the written value for 0, 1 and 3. A written value of 2 leaves the field unchanged.
- R7: Bit XLEN-1 of the status word reads as 1 exactly when bits 14:13 (float state) or bits 16:15 (extension state) are both ones.
- R8: A status write whose value differs from the stored word in VM (28:24), previous privilege (12:11), modify-privilege (17) or user-memory-protect (18) makes `tlb_flush_o` high for the single cycle after the write edge.
- R9: The VM field takes only legal translation modes: 0, or 9 and 10 when XLEN is 64, or 8 when XLEN is 32. An illegal value leaves the field unchanged.
- R10: The two counter-enable registers (0x320, 0x321) keep only their low three bits.
- R11: A memory-mapped store to offset 0 sets pending bit 3 to bit 0 of the stored byte. A store to any other offset has no effect.
- R12: An access to an unimplemented address raises `csr_illegal_o` and returns zero. A write to such an address changes no state.
- R13: Reset sets the privilege to machine (3) and `boot_pc_o` to RESET_PC. It loads the machine trap vector with MTVEC_RESET and clears every other register.
- R14: The supervisor status view (0x100) exposes only bits 1, 5, 8, 14:13, 16:15 and 18, plus the summary-dirty bit. A write through it changes only those bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_addr_i | input | 12 | Register address |
| csr_wdata_i | input | XLEN | Write data |
| csr_we_i | input | 1 | Write enable |
| csr_rdata_o | output | XLEN | Read data for csr_addr_i |
| csr_illegal_o | output | 1 | Address not implemented |
| mmio_we_i | input | 1 | Memory-mapped store strobe |
| mmio_off_i | input | MMIO_AW | Store offset |
| mmio_byte_i | input | 8 | Stored byte |
| priv_o | output | 2 | Current privilege level |
| boot_pc_o | output | XLEN | Program counter loaded at reset |
| tlb_flush_o | output | 1 | One-cycle translation flush request |

## Verification
The write masks are driven with all-ones patterns, which expose any bit a mask lets through wrongly. Sparse single-field patterns show whether the legality filters keep or replace a field. Through the supervisor windows, writes are made while the delegation mask is both wide and narrow, so a view that ignores delegation gives a different readback. Status writes are paired: one changes only a translation control and one changes only an enable bit, which separates a correct flush condition from one that fires on any write. Memory-mapped stores with bit 0 set, bit 0 clear and a wrong offset tell the set, clear and ignore paths apart.

// File: rtl/csr_file_pkg.sv
package csr_file_pkg;

  localparam int unsigned CSR_AW = 12;

  typedef enum logic [1:0] {
    PRIV_U    = 2'd0,
    PRIV_S    = 2'd1,
    PRIV_RSVD = 2'd2,
    PRIV_M    = 2'd3
  } priv_e;

  // register addresses
  localparam logic [CSR_AW-1:0] A_SSTATUS = 12'h100;
  localparam logic [CSR_AW-1:0] A_SIE     = 12'h104;
  localparam logic [CSR_AW-1:0] A_STVEC   = 12'h105;
  localparam logic [CSR_AW-1:0] A_SIP     = 12'h144;
  localparam logic [CSR_AW-1:0] A_MSTATUS = 12'h300;
  localparam logic [CSR_AW-1:0] A_MIDELEG = 12'h303;
  localparam logic [CSR_AW-1:0] A_MIE     = 12'h304;
  localparam logic [CSR_AW-1:0] A_MTVEC   = 12'h305;
  localparam logic [CSR_AW-1:0] A_UCNTEN  = 12'h320;
  localparam logic [CSR_AW-1:0] A_SCNTEN  = 12'h321;
  localparam logic [CSR_AW-1:0] A_MIP     = 12'h344;

  // interrupt bit positions
  localparam int B_SSIP = 1;
  localparam int B_MSIP = 3;
  localparam int B_STIP = 5;
  localparam int B_MTIP = 7;
  localparam int B_SEIP = 9;
  localparam int B_COP  = 12;

  // status field positions
  localparam int S_SIE    = 1;
  localparam int S_MIE    = 3;
  localparam int S_SPIE   = 5;
  localparam int S_MPIE   = 7;
  localparam int S_SPP    = 8;
  localparam int S_MPP    = 11;
  localparam int S_FS     = 13;
  localparam int S_XS     = 15;
  localparam int S_MPRV   = 17;
  localparam int S_PUM    = 18;
  localparam int S_VM     = 24;
  localparam int VM_W     = 5;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_MSTATUS, SEL_SSTATUS, SEL_MIE, SEL_SIE, SEL_MIP,
    SEL_SIP, SEL_MIDELEG, SEL_MTVEC, SEL_STVEC, SEL_UCNT, SEL_SCNT
  } csr_sel_e;

  function automatic csr_sel_e csr_decode(input logic [CSR_AW-1:0] a);
    case (a)
      A_MSTATUS: return SEL_MSTATUS;
      A_SSTATUS: return SEL_SSTATUS;
      A_MIE:     return SEL_MIE;
      A_SIE:     return SEL_SIE;
      A_MIP:     return SEL_MIP;
      A_SIP:     return SEL_SIP;
      A_MIDELEG: return SEL_MIDELEG;
      A_MTVEC:   return SEL_MTVEC;
      A_STVEC:   return SEL_STVEC;
      A_UCNTEN:  return SEL_UCNT;
      A_SCNTEN:  return SEL_SCNT;
      default:   return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/csr_status.sv
module csr_status
  import csr_file_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_m_i,
  input  logic            we_s_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] mstatus_o,
  output logic [XLEN-1:0] sstatus_o,
  output logic            flush_o
);

  localparam logic [XLEN-1:0] ONE      = XLEN'(1);
  localparam logic [XLEN-1:0] FS_MASK  = ONE << S_FS | ONE << (S_FS + 1);
  localparam logic [XLEN-1:0] XS_MASK  = ONE << S_XS | ONE << (S_XS + 1);
  localparam logic [XLEN-1:0] MPP_MASK = ONE << S_MPP | ONE << (S_MPP + 1);
  localparam logic [XLEN-1:0] VM_MASK  = ((ONE << VM_W) - ONE) << S_VM;
  localparam logic [XLEN-1:0] BASE_MASK = ONE << S_SIE | ONE << S_SPIE | ONE << S_MIE
                                        | ONE << S_MPIE | ONE << S_SPP | FS_MASK
                                        | XS_MASK | ONE << S_MPRV | ONE << S_PUM;
  localparam logic [XLEN-1:0] SUP_MASK = ONE << S_SIE | ONE << S_SPIE | ONE << S_SPP
                                       | FS_MASK | XS_MASK | ONE << S_PUM;
  localparam logic [XLEN-1:0] FLUSH_MASK = VM_MASK | MPP_MASK | ONE << S_MPRV
                                         | ONE << S_PUM;

  function automatic logic vm_legal(input logic [VM_W-1:0] v);
    if (v == '0) return 1'b1;
    if (XLEN == 64) return (v == VM_W'(9)) || (v == VM_W'(10));
    return v == VM_W'(8);
  endfunction

  logic [XLEN-1:0] stat_q, stat_d, src, mask;
  logic            wr, chg, dirty, flush_q;

  assign wr = we_m_i | we_s_i;

  always_comb begin
    src = we_s_i ? ((stat_q & ~SUP_MASK) | (wdata_i & SUP_MASK)) : wdata_i;
    mask = BASE_MASK;
    if (vm_legal(src[S_VM +: VM_W])) mask = mask | VM_MASK;
    if (src[S_MPP +: 2] != PRIV_RSVD) mask = mask | MPP_MASK;
    stat_d = (stat_q & ~mask) | (src & mask);
    chg    = |((src ^ stat_q) & FLUSH_MASK);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q  <= '0;
      flush_q <= 1'b0;
    end else begin
      flush_q <= wr & chg;
      if (wr) stat_q <= stat_d;
    end
  end

  assign dirty     = (&stat_q[S_FS +: 2]) | (&stat_q[S_XS +: 2]);
  assign mstatus_o = stat_q | ({XLEN{dirty}} & (ONE << (XLEN - 1)));
  assign sstatus_o = (stat_q & SUP_MASK) | ({XLEN{dirty}} & (ONE << (XLEN - 1)));
  assign flush_o   = flush_q;

  // R6: reserved previous-privilege value keeps the old field
  a_r6_mpp_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_m_i && wdata_i[S_MPP +: 2] == 2'd2) |=> stat_q[S_MPP +: 2] == $past(stat_q[S_MPP +: 2]));

  // R9: illegal VM value keeps the old field
  a_r9_vm_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_m_i && !vm_legal(wdata_i[S_VM +: VM_W])) |=> stat_q[S_VM +: VM_W] == $past(stat_q[S_VM +: VM_W]));

  // R8: flush only follows a status write
  a_r8_flush_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> $past(wr));

  // R14: supervisor write leaves machine-only bits alone
  a_r14_sup_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_s_i && !we_m_i |=> (stat_q & ~SUP_MASK) == $past(stat_q & ~SUP_MASK));

endmodule

// File: rtl/csr_irq.sv
module csr_irq
  import csr_file_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_mie_i,
  input  logic            we_sie_i,
  input  logic            we_mip_i,
  input  logic            we_sip_i,
  input  logic            we_deleg_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic            mmio_hit_i,
  input  logic            mmio_bit_i,
  output logic [XLEN-1:0] mip_o,
  output logic [XLEN-1:0] mie_o,
  output logic [XLEN-1:0] deleg_o,
  output logic [XLEN-1:0] sip_o,
  output logic [XLEN-1:0] sie_o
);

  localparam logic [XLEN-1:0] ONE        = XLEN'(1);
  localparam logic [XLEN-1:0] DELEG_MASK = ONE << B_SSIP | ONE << B_STIP
                                         | ONE << B_SEIP | ONE << B_COP;
  localparam logic [XLEN-1:0] ALL_MASK   = DELEG_MASK | ONE << B_MSIP | ONE << B_MTIP;
  localparam logic [XLEN-1:0] SW_MASK    = ONE << B_SSIP | ONE << B_STIP;

  logic [XLEN-1:0] mip_q, mie_q, deleg_q;
  logic [XLEN-1:0] mie_src, mip_src, mip_d;

  always_comb begin
    mie_src = we_sie_i ? ((mie_q & ~deleg_q) | (wdata_i & deleg_q)) : wdata_i;
    mip_src = we_sip_i ? ((mip_q & ~deleg_q) | (wdata_i & deleg_q)) : wdata_i;
    mip_d   = mip_q;
    if (we_mip_i || we_sip_i) mip_d = (mip_q & ~SW_MASK) | (mip_src & SW_MASK);
    if (mmio_hit_i) mip_d[B_MSIP] = mmio_bit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mip_q   <= '0;
      mie_q   <= '0;
      deleg_q <= '0;
    end else begin
      mip_q <= mip_d;
      if (we_mie_i || we_sie_i) mie_q <= (mie_q & ~ALL_MASK) | (mie_src & ALL_MASK);
      if (we_deleg_i) deleg_q <= (deleg_q & ~DELEG_MASK) | (wdata_i & DELEG_MASK);
    end
  end

  assign mip_o   = mip_q;
  assign mie_o   = mie_q;
  assign deleg_o = deleg_q;
  assign sip_o   = mip_q & deleg_q;
  assign sie_o   = mie_q & deleg_q;

  a_r1_deleg_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_deleg_i |=> deleg_q == ($past(wdata_i) & DELEG_MASK));

  a_r2_mie_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_mie_i || we_sie_i) |=> (mie_q & ~ALL_MASK) == '0);

  a_r3_mip_sw_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((we_mip_i || we_sip_i) && !mmio_hit_i) |=> (mip_q & ~SW_MASK) == $past(mip_q & ~SW_MASK));

  // R4: supervisor enable write keeps undelegated bits
  a_r4_sie_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_sie_i && !we_mie_i) |=> (mie_q & ~$past(deleg_q)) == ($past(mie_q) & ~$past(deleg_q)));

  a_r11_mmio_msip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mmio_hit_i |=> mip_q[B_MSIP] == $past(mmio_bit_i));

endmodule

// File: rtl/csr_tvec_reg.sv
module csr_tvec_reg #(
  parameter int unsigned     XLEN      = 64,
  parameter logic [XLEN-1:0] RESET_VAL = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] val_o
);

  logic [XLEN-3:0] base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   base_q <= RESET_VAL[XLEN-1:2];
    else if (we_i) base_q <= wdata_i[XLEN-1:2];
  end

  assign val_o = {base_q, 2'b00};

  a_r5_tvec_align: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> val_o == {$past(wdata_i[XLEN-1:2]), 2'b00});

endmodule

// File: rtl/csr_cnten_reg.sv
module csr_cnten_reg #(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned CNTEN_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] val_o
);

  logic [CNTEN_W-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_q <= '0;
    else if (we_i) en_q <= wdata_i[CNTEN_W-1:0];
  end

  assign val_o = XLEN'(en_q);

  a_r10_cnten_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> val_o == XLEN'($past(wdata_i[CNTEN_W-1:0])));

endmodule

// File: rtl/csr_file.sv
module csr_file
  import csr_file_pkg::*;
#(
  parameter int unsigned     XLEN        = 64,
  parameter int unsigned     MMIO_AW     = 4,
  parameter int unsigned     CNTEN_W     = 3,
  parameter logic [XLEN-1:0] RESET_PC    = XLEN'('h1000),
  parameter logic [XLEN-1:0] MTVEC_RESET = XLEN'('h100)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CSR_AW-1:0]  csr_addr_i,
  input  logic [XLEN-1:0]    csr_wdata_i,
  input  logic               csr_we_i,
  output logic [XLEN-1:0]    csr_rdata_o,
  output logic               csr_illegal_o,
  input  logic               mmio_we_i,
  input  logic [MMIO_AW-1:0] mmio_off_i,
  input  logic [7:0]         mmio_byte_i,
  output logic [1:0]         priv_o,
  output logic [XLEN-1:0]    boot_pc_o,
  output logic               tlb_flush_o
);

  localparam int unsigned NVEC = 2;   // 0: machine, 1: supervisor

  csr_sel_e        sel;
  logic            wr;
  logic [XLEN-1:0] mstatus, sstatus, mip, mie, deleg, sip, sie;
  logic [NVEC-1:0] tvec_we, cnt_we;
  logic [XLEN-1:0] tvec_val [NVEC];
  logic [XLEN-1:0] cnt_val  [NVEC];
  priv_e           priv_q;
  logic [XLEN-1:0] boot_pc_q;

  assign sel = csr_decode(csr_addr_i);
  assign wr  = csr_we_i && (sel != SEL_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      priv_q    <= PRIV_M;
      boot_pc_q <= RESET_PC;
    end
  end

  csr_status #(.XLEN(XLEN)) u_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_m_i    (wr && sel == SEL_MSTATUS),
    .we_s_i    (wr && sel == SEL_SSTATUS),
    .wdata_i   (csr_wdata_i),
    .mstatus_o (mstatus),
    .sstatus_o (sstatus),
    .flush_o   (tlb_flush_o)
  );

  csr_irq #(.XLEN(XLEN)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_mie_i   (wr && sel == SEL_MIE),
    .we_sie_i   (wr && sel == SEL_SIE),
    .we_mip_i   (wr && sel == SEL_MIP),
    .we_sip_i   (wr && sel == SEL_SIP),
    .we_deleg_i (wr && sel == SEL_MIDELEG),
    .wdata_i    (csr_wdata_i),
    .mmio_hit_i (mmio_we_i && mmio_off_i == '0),
    .mmio_bit_i (mmio_byte_i[0]),
    .mip_o      (mip),
    .mie_o      (mie),
    .deleg_o    (deleg),
    .sip_o      (sip),
    .sie_o      (sie)
  );

  assign tvec_we[0] = wr && sel == SEL_MTVEC;
  assign tvec_we[1] = wr && sel == SEL_STVEC;
  assign cnt_we[0]  = wr && sel == SEL_UCNT;
  assign cnt_we[1]  = wr && sel == SEL_SCNT;

  for (genvar g = 0; g < NVEC; g++) begin : g_pair
    localparam logic [XLEN-1:0] TV_RST = (g == 0) ? MTVEC_RESET : '0;

    csr_tvec_reg #(.XLEN(XLEN), .RESET_VAL(TV_RST)) u_tvec (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (tvec_we[g]),
      .wdata_i (csr_wdata_i),
      .val_o   (tvec_val[g])
    );

    csr_cnten_reg #(.XLEN(XLEN), .CNTEN_W(CNTEN_W)) u_cnten (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (cnt_we[g]),
      .wdata_i (csr_wdata_i),
      .val_o   (cnt_val[g])
    );
  end

  always_comb begin
    case (sel)
      SEL_MSTATUS: csr_rdata_o = mstatus;
      SEL_SSTATUS: csr_rdata_o = sstatus;
      SEL_MIE:     csr_rdata_o = mie;
      SEL_SIE:     csr_rdata_o = sie;
      SEL_MIP:     csr_rdata_o = mip;
      SEL_SIP:     csr_rdata_o = sip;
      SEL_MIDELEG: csr_rdata_o = deleg;
      SEL_MTVEC:   csr_rdata_o = tvec_val[0];
      SEL_STVEC:   csr_rdata_o = tvec_val[1];
      SEL_UCNT:    csr_rdata_o = cnt_val[0];
      SEL_SCNT:    csr_rdata_o = cnt_val[1];
      default:     csr_rdata_o = '0;
    endcase
  end

  assign csr_illegal_o = (sel == SEL_NONE);
  assign priv_o        = priv_q;
  assign boot_pc_o     = boot_pc_q;

  a_r12_illegal_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_illegal_o |-> csr_rdata_o == '0);

  // R7: summary-dirty tracks the float/extension state of the stored word
  a_r7_sd_view: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sstatus[XLEN-1] == mstatus[XLEN-1]);

  a_r13_priv_machine: assert property (@(posedge clk_i) disable iff (!rst_ni)
    priv_o == PRIV_M && boot_pc_o == RESET_PC);

endmodule

// File: tb/csr_file_bench.sv
module csr_file_bench;

  typedef struct packed {
    logic [11:0] waddr;
    logic [63:0] wdata;
    logic [11:0] raddr;
    logic [63:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{12'h303, 64'hFFFF_FFFF_FFFF_FFFF, 12'h303, 64'h1222, 8'd1},   // R1
    '{12'h304, 64'hFFFF_FFFF_FFFF_FFFF, 12'h304, 64'h12AA, 8'd2},   // R2
    '{12'h104, 64'h0,                   12'h304, 64'h0088, 8'd4},   // R4
    '{12'h104, 64'h200,                 12'h104, 64'h0200, 8'd4},   // R4
    '{12'h344, 64'hFFFF_FFFF_FFFF_FFFF, 12'h344, 64'h0022, 8'd3},   // R3
    '{12'h303, 64'h2,                   12'h144, 64'h0002, 8'd4},   // R4
    '{12'h144, 64'h0,                   12'h344, 64'h0020, 8'd4},   // R4
    '{12'h305, 64'h1237,                12'h305, 64'h1234, 8'd5},   // R5
    '{12'h105, 64'hFFFF_FFFF_FFFF_FFFF, 12'h105, 64'hFFFF_FFFF_FFFF_FFFC, 8'd5}, // R5
    '{12'h300, 64'h1800,                12'h300, 64'h1800, 8'd6},   // R6
    '{12'h300, 64'h1000,                12'h300, 64'h1800, 8'd6},   // R6
    '{12'h300, 64'h0800,                12'h300, 64'h0800, 8'd6},   // R6
    '{12'h300, 64'h6000,                12'h300, 64'h8000_0000_0000_6000, 8'd7}, // R7
    '{12'h100, 64'hFFFF_FFFF_FFFF_FFFF, 12'h100, 64'h8000_0000_0005_E122, 8'd14}, // R14
    '{12'h300, 64'h0900_0000,           12'h300, 64'h0900_0000, 8'd9}, // R9
    '{12'h300, 64'h0300_0000,           12'h300, 64'h0900_0000, 8'd9}, // R9
    '{12'h320, 64'hFF,                  12'h320, 64'h7, 8'd10},     // R10
    '{12'h321, 64'hFFFF,                12'h321, 64'h7, 8'd10}      // R10
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic [63:0] wdata = '0;
  logic        we = 1'b0;
  logic [63:0] rdata;
  logic        illegal;
  logic        mmio_we = 1'b0;
  logic [3:0]  mmio_off = '0;
  logic [7:0]  mmio_byte = '0;
  logic [1:0]  priv;
  logic [63:0] boot_pc;
  logic        flush;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  csr_file u_csr_file (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .csr_addr_i    (addr),
    .csr_wdata_i   (wdata),
    .csr_we_i      (we),
    .csr_rdata_o   (rdata),
    .csr_illegal_o (illegal),
    .mmio_we_i     (mmio_we),
    .mmio_off_i    (mmio_off),
    .mmio_byte_i   (mmio_byte),
    .priv_o        (priv),
    .boot_pc_o     (boot_pc),
    .tlb_flush_o   (flush)
  );

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic do_read(input logic [11:0] a, output logic [63:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic do_store(input logic [3:0] off, input logic [7:0] b);
    @(negedge clk);
    mmio_off = off; mmio_byte = b; mmio_we = 1'b1;
    @(negedge clk);
    mmio_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R13: reset state
    chk(64'(priv), 64'h3, "R13 priv");
    chk(boot_pc, 64'h1000, "R13 boot_pc");
    do_read(12'h305, v); chk(v, 64'h100, "R13 mtvec");
    do_read(12'h300, v); chk(v, 64'h0, "R13 mstatus");
    do_read(12'h304, v); chk(v, 64'h0, "R13 mie");
    do_read(12'h344, v); chk(v, 64'h0, "R13 mip");
    do_read(12'h303, v); chk(v, 64'h0, "R13 deleg");
    do_read(12'h105, v); chk(v, 64'h0, "R13 stvec");
    chk(64'(flush), 64'h0, "R13 flush");

    for (int i = 0; i < NV; i++) begin
      do_write(VECS[i].waddr, VECS[i].wdata);
      do_read(VECS[i].raddr, v);
      chk(v, VECS[i].exp, $sformatf("R%0d vec%0d", VECS[i].req, i));
      chk(64'(illegal), 64'h0, $sformatf("R12 legal vec%0d", i));
    end

    // R12: unimplemented address
    do_read(12'h7C0, v);
    chk(v, 64'h0, "R12 rdata");
    chk(64'(illegal), 64'h1, "R12 flag");
    do_write(12'h7C0, 64'hFFFF_FFFF_FFFF_FFFF);
    do_read(12'h344, v); chk(v, 64'h20, "R12 no effect mip");
    do_read(12'h303, v); chk(v, 64'h2, "R12 no effect deleg");

    // R11: memory-mapped software interrupt
    do_store(4'h0, 8'h01);
    do_read(12'h344, v); chk(v, 64'h28, "R11 set");
    do_store(4'h4, 8'h00);
    do_read(12'h344, v); chk(v, 64'h28, "R11 other offset");
    do_store(4'h0, 8'hFE);
    do_read(12'h344, v); chk(v, 64'h20, "R11 clear");

    // R8: flush pulse (mstatus now 0x0900_0000)
    do_write(12'h300, 64'h0902_0000);
    chk(64'(flush), 64'h1, "R8 flush on MPRV");
    @(negedge clk);
    chk(64'(flush), 64'h0, "R8 single cycle");
    do_write(12'h300, 64'h0902_0002);
    chk(64'(flush), 64'h0, "R8 no flush on SIE");
    do_read(12'h300, v); chk(v, 64'h0902_0002, "R8 value");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule